// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether a received frame's destination address falls into one of 256 enabled multicast bins. When an address is presented with a strobe, the block folds its six bytes into a CRC-32 register, one byte per clock. The top eight bits of the result are used to look up a 256-entry bit table, which is held as eight 32-bit words. The block returns a hit flag together with a one-cycle completion pulse.

Software shapes the table through a narrow write port. Each access either replaces a whole word, ORs a mask into it, or clears the masked bits. Setting or removing one bin is a single access with a one-hot mask. Only group addresses are looked up. An individual address always completes with no hit, so exact unicast matching and promiscuous handling are left to other blocks.

Top module: `mhf_group_filter`

## Requirements
- R1: The table index is bits [31:24] of a CRC-32 computed as follows. The register starts at all ones and uses generator 0x04C11DB7, shifting out at the most significant bit. Each address byte enters least significant bit first. Bytes go in from da_addr[47:40] down to da_addr[7:0]. No final inversion is applied.
- R2: Index bits [7:5] select the word, with the same numbering as tbl_wr_sel. Index bits [4:0], read as n, select word bit 31-n. So bin 0 is word 0 bit 31, and bin 255 is word 7 bit 0.
- R3: Reset clears all eight words and holds hit and hit_done low. A group lookup made right after reset gives no hit.
- R4: A table access is sampled on a clock edge with tbl_wr_en high. tbl_wr_op selects the action: 00 loads tbl_wr_data into the word, 01 ORs tbl_wr_data into it, 10 clears the bits set in tbl_wr_data, and 11 changes nothing. The other words are never touched.
- R5: The group bit is da_addr[40]. When it is 0 the lookup still completes, but hit stays 0.
- R6: If da_valid is accepted in cycle t, hit_done is high in cycle t+7 and only there. hit is valid in that cycle and low in every cycle where hit_done is low.
- R7: da_valid is ignored in the six cycles that follow an accepted address. It produces no extra completion and does not change the pending result.
- R8: A table access sampled in cycle t+6 of a lookup accepted in cycle t does not affect that lookup's result. It does affect every later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table access strobe |
| tbl_wr_op | input | 2 | Access kind: load, OR, AND-NOT, none |
| tbl_wr_sel | input | 3 | Word select |
| tbl_wr_data | input | 32 | Word value or bit mask |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, first byte in [47:40] |
| hit | output | 1 | Address falls into an enabled bin |
| hit_done | output | 1 | One-cycle completion pulse |

## Verification
The inline properties run on every cycle. They cover the fixed seven-cycle completion distance, hit being seen only with hit_done, the single-cycle pulse, and individual addresses never hitting. They also cover the effect of each table access on the word it names, the cleared table at reset release, and the sequencer holding its captured address while busy. The scenarios are the only place the CRC folding and the MSB-first bin placement are shown, since they compare results against an independently written reflected CRC. The same holds for the ordering of a table access against a lookup in the same cycle and for a strobe dropped while busy.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   typedef enum logic [1:0] {
      TBL_LOAD = 2'b00,
      TBL_SET  = 2'b01,
      TBL_CLR  = 2'b10,
      TBL_NOP  = 2'b11
   } tbl_op_e;

endpackage

// File: rtl/mhf_crc_seq.sv
module mhf_crc_seq #(
   parameter int ADDR_BYTES = 6,
   parameter int CRC_W      = 32,
   parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
   parameter int IDX_W      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_BYTES*8-1:0] addr,
   output logic                    accept,
   output logic                    busy,
   output logic                    idx_valid,
   output logic [IDX_W-1:0]        idx,
   output logic                    group
);

   localparam int ADDR_W = ADDR_BYTES * 8;
   localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

   logic [CRC_W-1:0]  crc_q, crc_nxt;
   logic [ADDR_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q, grp_q;
   logic [7:0]        cur_byte;

   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                 input logic [7:0] d);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[CRC_W-1] ^ d[i];
         c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      return c;
   endfunction

   assign accept   = start && !busy_q;
   assign cur_byte = accept ? addr[ADDR_W-1 -: 8] : sh_q[ADDR_W-1 -: 8];
   assign crc_nxt  = crc_step(accept ? '1 : crc_q, cur_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         crc_q  <= '0;
         sh_q   <= '0;
         grp_q  <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(1);
         crc_q  <= crc_nxt;
         sh_q   <= addr << 8;
         grp_q  <= addr[ADDR_W-8];
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            crc_q <= crc_nxt;
            sh_q  <= sh_q << 8;
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign busy      = busy_q;
   assign idx_valid = busy_q && (cnt_q == LAST);
   assign idx       = crc_q[CRC_W-1 -: IDX_W];
   assign group     = grp_q;

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_busy_holds_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy_q) |=> $stable(grp_q));

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
   import mhf_pkg::*;
#(
   parameter int NUM_REGS  = 8,
   parameter int REG_W     = 32,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [1:0]                     wr_op,
   input  logic [$clog2(NUM_REGS)-1:0]    wr_sel,
   input  logic [REG_W-1:0]               wr_data,
   input  logic                           rd_en,
   input  logic [$clog2(NUM_REGS*REG_W)-1:0] rd_idx,
   input  logic                           rd_gate,
   output logic                           done,
   output logic                           match
);

   localparam int SEL_W = $clog2(NUM_REGS);
   localparam int BIT_W = $clog2(REG_W);
   localparam int IDX_W = SEL_W + BIT_W;

   logic [REG_W-1:0] regs [NUM_REGS];
   logic [SEL_W-1:0] rd_sel;
   logic [BIT_W-1:0] rd_low, rd_pos;
   logic [REG_W-1:0] rd_word;
   logic             done_q, match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NUM_REGS; g++) regs[g] <= '0;
      end else if (wr_en) begin
         for (int g = 0; g < NUM_REGS; g++) begin
            if (wr_sel == SEL_W'(g)) begin
               case (tbl_op_e'(wr_op))
                  TBL_LOAD: regs[g] <= wr_data;
                  TBL_SET:  regs[g] <= regs[g] | wr_data;
                  TBL_CLR:  regs[g] <= regs[g] & ~wr_data;
                  default:  regs[g] <= regs[g];
               endcase
            end
         end
      end
   end

   assign rd_sel  = rd_idx[IDX_W-1 -: SEL_W];
   assign rd_low  = rd_idx[BIT_W-1:0];
   assign rd_word = regs[rd_sel];

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign rd_pos = BIT_W'(REG_W - 1) - rd_low;
      end else begin : g_lsb_first
         assign rd_pos = rd_low;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         match_q <= 1'b0;
      end else begin
         done_q  <= rd_en;
         match_q <= rd_en && rd_gate && rd_word[rd_pos];
      end
   end

   assign done  = done_q;
   assign match = match_q;

   assert_load_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'b00) |=> regs[$past(wr_sel)] == $past(wr_data));

   assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'b01) |=>
         (regs[$past(wr_sel)] & $past(wr_data)) == $past(wr_data));

   assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'b10) |=> (regs[$past(wr_sel)] & $past(wr_data)) == '0);

   assert_nop_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'b11) |=> $stable(regs[$past(wr_sel)]));

   assert_reset_empty_R3: assert property (@(posedge clk)
      $rose(rst_n) |-> (regs[0] == '0 && regs[NUM_REGS-1] == '0));

endmodule

// File: rtl/mhf_group_filter.sv
module mhf_group_filter #(
   parameter int ADDR_BYTES = 6,
   parameter int NUM_REGS   = 8,
   parameter int REG_W      = 32,
   parameter int CRC_W      = 32,
   parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tbl_wr_en,
   input  logic [1:0]                    tbl_wr_op,
   input  logic [$clog2(NUM_REGS)-1:0]   tbl_wr_sel,
   input  logic [REG_W-1:0]              tbl_wr_data,
   input  logic                          da_valid,
   input  logic [ADDR_BYTES*8-1:0]       da_addr,
   output logic                          hit,
   output logic                          hit_done
);

   localparam int IDX_W   = $clog2(NUM_REGS * REG_W);
   localparam int LATENCY = ADDR_BYTES + 1;

   generate
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two of at least 2");
      end
      if (REG_W < 2 || (REG_W & (REG_W - 1)) != 0) begin : g_bad_width
         $error("REG_W must be a power of two of at least 2");
      end
      if (IDX_W > CRC_W) begin : g_bad_idx
         $error("table index wider than the CRC");
      end
      if (ADDR_BYTES < 1) begin : g_bad_addr
         $error("ADDR_BYTES must be at least 1");
      end
   endgenerate

   logic             accept_w, busy_w, idx_valid_w, group_w;
   logic [IDX_W-1:0] idx_w;

   mhf_crc_seq #(
      .ADDR_BYTES(ADDR_BYTES),
      .CRC_W     (CRC_W),
      .POLY      (POLY),
      .IDX_W     (IDX_W)
   ) i_crc_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (da_valid),
      .addr     (da_addr),
      .accept   (accept_w),
      .busy     (busy_w),
      .idx_valid(idx_valid_w),
      .idx      (idx_w),
      .group    (group_w)
   );

   mhf_hash_table #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .MSB_FIRST(MSB_FIRST)
   ) i_hash_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr_en),
      .wr_op  (tbl_wr_op),
      .wr_sel (tbl_wr_sel),
      .wr_data(tbl_wr_data),
      .rd_en  (idx_valid_w),
      .rd_idx (idx_w),
      .rd_gate(group_w),
      .done   (hit_done),
      .match  (hit)
   );

   assert_hit_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> hit_done);

   assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_done |=> !hit_done);

   assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_done |-> $past(accept_w, LATENCY));

   assert_unicast_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(accept_w && !da_addr[ADDR_BYTES*8-8], LATENCY) |-> !hit);

   assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_done |-> !busy_w || $past(busy_w));

endmodule

// File: tb/test_mhf_group_filter.sv
module test_mhf_group_filter;

   localparam int CLK_P = 10;

   logic        clk, rst_n;
   logic        tbl_wr_en;
   logic [1:0]  tbl_wr_op;
   logic [2:0]  tbl_wr_sel;
   logic [31:0] tbl_wr_data;
   logic        da_valid;
   logic [47:0] da_addr;
   logic        hit, hit_done;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;
   logic [31:0] shadow [8];

   mhf_group_filter i_mhf_group_filter (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_op(tbl_wr_op),
      .tbl_wr_sel(tbl_wr_sel), .tbl_wr_data(tbl_wr_data),
      .da_valid(da_valid), .da_addr(da_addr),
      .hit(hit), .hit_done(hit_done)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_P/2) clk = ~clk;
   end

   // Reflected-form CRC; the reversed low byte equals the top byte of R1's register.
   function automatic logic [7:0] bin_of(input logic [47:0] a);
      logic [31:0] c;
      logic [7:0]  r;
      c = 32'hFFFF_FFFF;
      for (int b = 5; b >= 0; b--) begin
         c = c ^ {24'h0, a[b*8 +: 8]};
         for (int k = 0; k < 8; k++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      for (int k = 0; k < 8; k++) r[k] = c[7-k];
      return r;
   endfunction

   function automatic logic [47:0] addr_for(input logic [7:0] bin, input logic grp);
      logic [47:0] a;
      for (int k = 0; k < 65536; k++) begin
         a = {grp ? 8'h01 : 8'h02, 8'h5E, 8'h33, 8'h7A, 16'(k)};
         if (bin_of(a) == bin) return a;
      end
      return a;
   endfunction

   function automatic logic expect_hit(input logic [47:0] a);
      logic [7:0] b;
      b = bin_of(a);
      return a[40] && shadow[b[7:5]][31 - b[4:0]];
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic shadow_apply(input logic [1:0] op, input logic [2:0] sel,
                               input logic [31:0] d);
      case (op)
         2'b00: shadow[sel] = d;
         2'b01: shadow[sel] = shadow[sel] | d;
         2'b10: shadow[sel] = shadow[sel] & ~d;
         default: ;
      endcase
   endtask

   task automatic do_write(input logic [1:0] op, input logic [2:0] sel,
                           input logic [31:0] d);
      tbl_wr_en = 1'b1; tbl_wr_op = op; tbl_wr_sel = sel; tbl_wr_data = d;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      shadow_apply(op, sel, d);
   endtask

   task automatic lookup(input logic [47:0] a, input string req);
      logic exp, early;
      exp = expect_hit(a);
      early = 1'b0;
      da_valid = 1'b1; da_addr = a;
      @(negedge clk);
      da_valid = 1'b0;
      for (int i = 1; i < 7; i++) begin
         if (hit_done) early = 1'b1;
         @(negedge clk);
      end
      check(!early && hit_done, "R6 done timing", {31'h0, hit_done}, 32'h1);
      check(hit == exp, req, {31'h0, hit}, {31'h0, exp});
      @(negedge clk);
      check(!hit_done && !hit, "R6 single pulse", {30'h0, hit_done, hit}, 32'h0);
   endtask

   task automatic t_reset;
      check(!hit && !hit_done, "R3 outputs in reset", {30'h0, hit, hit_done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      lookup(addr_for(8'd0, 1'b1), "R3 empty table bin 0");
      lookup(addr_for(8'd200, 1'b1), "R3 empty table bin 200");
   endtask

   task automatic t_bit_order;
      do_write(2'b01, 3'd0, 32'h8000_0000);
      lookup(addr_for(8'd0, 1'b1), "R2 bin 0 is word 0 bit 31");
      lookup(addr_for(8'd31, 1'b1), "R2 bin 31 not set");
      do_write(2'b01, 3'd7, 32'h0000_0001);
      lookup(addr_for(8'd255, 1'b1), "R2 bin 255 is word 7 bit 0");
      lookup(addr_for(8'd224, 1'b1), "R2 bin 224 not set");
   endtask

   task automatic t_ops;
      do_write(2'b00, 3'd3, 32'h0000_FFFF);
      lookup(addr_for(8'd112, 1'b1), "R4 load sets bin 112");
      lookup(addr_for(8'd111, 1'b1), "R4 load leaves bin 111 clear");
      do_write(2'b01, 3'd3, 32'h8000_0000);
      lookup(addr_for(8'd96, 1'b1), "R4 OR sets bin 96");
      lookup(addr_for(8'd112, 1'b1), "R4 OR keeps bin 112");
      do_write(2'b10, 3'd3, 32'h0000_FFFF);
      lookup(addr_for(8'd112, 1'b1), "R4 AND-NOT clears bin 112");
      lookup(addr_for(8'd96, 1'b1), "R4 AND-NOT keeps bin 96");
      do_write(2'b11, 3'd3, 32'hFFFF_FFFF);
      lookup(addr_for(8'd100, 1'b1), "R4 op 11 changes nothing");
      do_write(2'b00, 3'd7, 32'h0);
      lookup(addr_for(8'd0, 1'b1), "R4 other words untouched");
   endtask

   task automatic t_crc;
      logic [47:0] a;
      for (int r = 0; r < 8; r++)
         do_write(2'b00, 3'(r), 32'hA5C3_0F96 ^ (32'h1111_1111 * r));
      for (int k = 0; k < 24; k++) begin
         a = {8'h01 | (8'(k) << 1), 8'(k * 37), 8'hC4, 8'(k * 91), 8'h2B ^ 8'(k), 8'(k * 13)};
         lookup(a, "R1 CRC bin selection");
      end
   endtask

   task automatic t_unicast;
      for (int r = 0; r < 8; r++) do_write(2'b00, 3'(r), 32'hFFFF_FFFF);
      lookup(addr_for(8'd5, 1'b0), "R5 individual address no hit");
      lookup(addr_for(8'd77, 1'b0), "R5 individual address no hit");
      lookup(addr_for(8'd77, 1'b1), "R5 group address hits full table");
   endtask

   task automatic t_busy;
      logic [47:0] a_first, a_second;
      logic extra;
      a_first  = addr_for(8'd9, 1'b0);
      a_second = addr_for(8'd9, 1'b1);
      extra = 1'b0;
      da_valid = 1'b1; da_addr = a_first;
      @(negedge clk);
      da_valid = 1'b0;
      for (int i = 1; i < 7; i++) begin
         if (i == 3) begin da_valid = 1'b1; da_addr = a_second; end
         else da_valid = 1'b0;
         @(negedge clk);
      end
      da_valid = 1'b0;
      check(hit_done && !hit, "R7 first address result kept", {30'h0, hit_done, hit}, 32'h2);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (hit_done) extra = 1'b1;
      end
      check(!extra, "R7 busy strobe ignored", {31'h0, extra}, 32'h0);
   endtask

   task automatic t_same_cycle;
      logic [47:0] a;
      logic [7:0]  b;
      for (int r = 0; r < 8; r++) do_write(2'b00, 3'(r), 32'h0);
      b = 8'd170;
      a = addr_for(b, 1'b1);
      da_valid = 1'b1; da_addr = a;
      @(negedge clk);
      da_valid = 1'b0;
      for (int i = 1; i < 7; i++) begin
         if (i == 6) begin
            tbl_wr_en = 1'b1; tbl_wr_op = 2'b01; tbl_wr_sel = b[7:5];
            tbl_wr_data = 32'h8000_0000 >> b[4:0];
         end
         @(negedge clk);
      end
      tbl_wr_en = 1'b0;
      check(hit_done && !hit, "R8 write in lookup cycle not seen", {30'h0, hit_done, hit}, 32'h2);
      shadow_apply(2'b01, b[7:5], 32'h8000_0000 >> b[4:0]);
      @(negedge clk);
      lookup(a, "R8 write seen by next lookup");
   endtask

   initial begin
      for (int r = 0; r < 8; r++) shadow[r] = 32'h0;
      tbl_wr_en = 1'b0; tbl_wr_op = 2'b00; tbl_wr_sel = 3'd0; tbl_wr_data = 32'h0;
      da_valid = 1'b0; da_addr = 48'h0;
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset;
      t_bit_order;
      t_ops;
      t_crc;
      t_unicast;
      t_busy;
      t_same_cycle;
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         finished = 1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule